// File: doc/BRIEF.md
# Streaming FIR Multiply-Accumulate Engine

This block computes one output of a fixed-point FIR filter each time it is started. Input samples sit in a circular sample ring that an external DMA-style writer fills through its own write port. Filter coefficients sit in a separate table. For each output the engine sweeps a window of the sample ring. It multiplies each sample, or each sum of a mirrored sample pair, by a coefficient and adds the product into a 40-bit accumulator. At the end of the sweep it rounds and saturates the sum to 16 bits and appends it to a circular result ring. An external reader reads the result ring through a registered read port.

Every MAC cycle reads three independently addressed memories at once: the coefficient, the forward sample and the mirrored sample. The sample ring is held as two identical copies that are written together, so the writer is never blocked and the sweep never stalls. In symmetric mode the engine adds the two samples that sit equally far from the window centre, then multiplies the sum by one shared coefficient. This covers two taps per cycle.

After each output the window start moves one sample further along the ring, and the result slot moves one entry further along the result ring. Both pointers wrap at their power-of-two depths.

Top module: `fir_sweep_engine`

## Requirements
- R1: In normal mode (sym_mode = 0) with N taps and window start b, the result is y = sum over i = 0..N-1 of c[i] * x[(b+i) mod IN_DEPTH], where c is the coefficient table and x is the sample ring.
- R2: In symmetric mode (sym_mode = 1) with even N, the result is y = sum over i = 0..N/2-1 of c[i] * (x[b+i] + x[b+N-1-i]), with ring indices taken mod IN_DEPTH. The pair sum is formed at 17 bits and never wraps.
- R3: The accumulator is 40 bits signed. A sweep of any legal length over full-scale operands never changes the sign of the accumulator through overflow.
- R4: The stored result is (acc + 2^14) shifted arithmetically right by 15 bits (round half up), then clamped to the range -32768..32767.
- R5: busy goes high on the clock edge that accepts start. It stays high for exactly L+3 cycles, where L = N in normal mode and L = N/2 in symmetric mode. The result is written on the edge where busy falls.
- R6: A start that arrives while busy is high is ignored: the sweep length does not change and only one result is appended.
- R7: A start is ignored when L is 0 or N exceeds the coefficient table depth. In that case busy stays low, no result is written and the window start does not move.
- R8: After reset the window start and the result slot are both 0. Each result moves the window start forward by 1 mod IN_DEPTH and the result slot forward by 1 mod OUT_DEPTH.
- R9: The sample ring accepts one write per cycle at any time, including during a sweep, without changing sweep timing. A sample written during a sweep is used by later sweeps.
- R10: res_rd_data shows the result ring entry at res_rd_addr one clock edge after the address is presented.
- R11: While reset is held and after it is released, busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_wr_en | input | 1 | Sample ring write enable |
| smp_wr_addr | input | IN_AW | Sample ring write address |
| smp_wr_data | input | 16 | Signed sample to write |
| cf_wr_en | input | 1 | Coefficient table write enable |
| cf_wr_addr | input | CF_AW | Coefficient index |
| cf_wr_data | input | 16 | Signed coefficient |
| res_rd_addr | input | OUT_AW | Result ring read address |
| res_rd_data | output | 16 | Registered result ring read data |
| start | input | 1 | Request one output sweep |
| sym_mode | input | 1 | 1 = symmetric pre-add mode, 0 = normal mode |
| tap_count | input | CF_AW+1 | Number of taps N |
| busy | output | 1 | Sweep in progress |

## Verification
Three cases are hard to reach from the ports. The first is a sample ring write that lands during a live sweep. The second is a start request that arrives while the engine is busy. The third is a window that straddles the end of the ring. For the first case, the bench keeps writing one address past the current window on every cycle of a sweep; the next sweep then reads that address as its last tap. For the second, it holds start high through the first busy cycles. For the third, it runs enough short sweeps that both ring pointers wrap several times, using a small ring size. Extreme operand sets are built by writing samples at the model's known window start. These cover round-half-up on both sides of zero, full-scale saturation and a mirrored pair whose sum needs the 17th bit.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int DW     = 16;
  localparam int ACC_W  = 40;
  localparam int PRE_W  = DW + 1;
  localparam int PROD_W = PRE_W + DW;
  localparam int FRAC   = 15;

  typedef logic signed [DW-1:0]     sample_t;
  typedef logic signed [PRE_W-1:0]  presum_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Q15 scaling with round half up, clamped to the 16-bit range
  function automatic sample_t round_sat(input acc_t a);
    acc_t r;
    r = (a + (acc_t'(1) <<< (FRAC - 1))) >>> FRAC;
    if (r > acc_t'(32767))
      return sample_t'(16'h7fff);
    else if (r < -acc_t'(32768))
      return sample_t'(16'h8000);
    else
      return sample_t'(r[DW-1:0]);
  endfunction
endpackage

// File: rtl/fir_dp_ram.sv
module fir_dp_ram #(
  parameter int AW = 8,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_seq.sv
module fir_seq #(
  parameter int IN_AW  = 10,
  parameter int OUT_AW = 8,
  parameter int CF_AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sym_mode,
  input  logic [CF_AW:0]    tap_count,
  input  logic              fin,
  output logic              busy,
  output logic              sym,
  output logic              issue,
  output logic              issue_last,
  output logic              acc_clr,
  output logic [IN_AW-1:0]  fwd_addr,
  output logic [IN_AW-1:0]  mir_addr,
  output logic [CF_AW-1:0]  cf_addr,
  output logic              out_we,
  output logic [OUT_AW-1:0] out_waddr
);
  localparam int CF_DEPTH = 1 << CF_AW;
  localparam int LW       = CF_AW + 1;

  logic              busy_r, issuing_r, sym_r;
  logic [LW-1:0]     len_r, n_r, eff_len, mir_off;
  logic [CF_AW-1:0]  idx_r;
  logic [IN_AW-1:0]  base_r;
  logic [OUT_AW-1:0] wptr_r;
  logic              accept, at_last;

  assign eff_len = sym_mode ? {1'b0, tap_count[CF_AW:1]} : tap_count;
  assign accept  = start && !busy_r && (eff_len != '0) &&
                   (tap_count <= LW'(CF_DEPTH));
  assign at_last = issuing_r && ({1'b0, idx_r} == len_r - LW'(1));
  assign mir_off = n_r - LW'(1) - {1'b0, idx_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r    <= 1'b0;
      issuing_r <= 1'b0;
      sym_r     <= 1'b0;
      len_r     <= '0;
      n_r       <= '0;
      idx_r     <= '0;
      base_r    <= '0;
      wptr_r    <= '0;
    end else begin
      if (accept) begin
        busy_r    <= 1'b1;
        issuing_r <= 1'b1;
        sym_r     <= sym_mode;
        len_r     <= eff_len;
        n_r       <= tap_count;
        idx_r     <= '0;
      end else if (issuing_r) begin
        idx_r <= idx_r + CF_AW'(1);
        if (at_last)
          issuing_r <= 1'b0;
      end
      if (fin) begin
        busy_r <= 1'b0;
        base_r <= base_r + IN_AW'(1);
        wptr_r <= wptr_r + OUT_AW'(1);
      end
    end
  end

  assign busy       = busy_r;
  assign sym        = sym_r;
  assign issue      = issuing_r;
  assign issue_last = at_last;
  assign acc_clr    = accept;
  assign fwd_addr   = base_r + IN_AW'(idx_r);
  assign mir_addr   = base_r + IN_AW'(mir_off);
  assign cf_addr    = idx_r;
  assign out_we     = fin;
  assign out_waddr  = wptr_r;

  AST_BUSY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    busy_r |=> (busy_r || $past(fin))); // R5
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    fin |-> busy_r); // R5
  AST_ISSUE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    issuing_r |-> busy_r); // R5
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_r && start) |=> ($stable(n_r) && $stable(len_r))); // R6
endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    acc_clr,
  input  logic    issue,
  input  logic    issue_last,
  input  logic    sym,
  input  sample_t smp_fwd,
  input  sample_t smp_mir,
  input  sample_t coef,
  output logic    fin,
  output sample_t result
);
  logic    rd_vld_r, rd_last_r, p_vld_r, p_last_r, fin_r;
  presum_t pre;
  prod_t   prod_r;
  acc_t    acc_r;

  // pair sum formed one bit wider than the samples
  assign pre = sym ? (presum_t'(smp_fwd) + presum_t'(smp_mir)) : presum_t'(smp_fwd);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_r  <= 1'b0;
      rd_last_r <= 1'b0;
      p_vld_r   <= 1'b0;
      p_last_r  <= 1'b0;
      fin_r     <= 1'b0;
      prod_r    <= '0;
      acc_r     <= '0;
    end else begin
      rd_vld_r  <= issue;
      rd_last_r <= issue_last;
      p_vld_r   <= rd_vld_r;
      p_last_r  <= rd_vld_r && rd_last_r;
      prod_r    <= pre * coef;
      if (acc_clr)
        acc_r <= '0;
      else if (p_vld_r)
        acc_r <= acc_r + acc_t'(prod_r);
      fin_r <= p_vld_r && p_last_r;
    end
  end

  assign fin    = fin_r;
  assign result = round_sat(acc_r);

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (p_vld_r && !acc_clr && (acc_r[ACC_W-1] == prod_r[PROD_W-1]))
      |=> (acc_r[ACC_W-1] == $past(acc_r[ACC_W-1]))); // R3
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fin_r |=> !fin_r); // R6
endmodule

// File: rtl/fir_sweep_engine.sv
module fir_sweep_engine
  import fir_pkg::*;
#(
  parameter int IN_AW  = 10,
  parameter int OUT_AW = 8,
  parameter int CF_AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_wr_en,
  input  logic [IN_AW-1:0]  smp_wr_addr,
  input  logic [DW-1:0]     smp_wr_data,
  input  logic              cf_wr_en,
  input  logic [CF_AW-1:0]  cf_wr_addr,
  input  logic [DW-1:0]     cf_wr_data,
  input  logic [OUT_AW-1:0] res_rd_addr,
  output logic [DW-1:0]     res_rd_data,
  input  logic              start,
  input  logic              sym_mode,
  input  logic [CF_AW:0]    tap_count,
  output logic              busy
);
  localparam int N_COPIES = 2;

  logic              sym, issue, issue_last, acc_clr, fin, out_we;
  logic [IN_AW-1:0]  ring_raddr [N_COPIES];
  logic [DW-1:0]     ring_rdata [N_COPIES];
  logic [CF_AW-1:0]  cf_addr;
  logic [DW-1:0]     cf_rdata;
  logic [OUT_AW-1:0] out_waddr;
  sample_t           result;

  fir_seq #(.IN_AW(IN_AW), .OUT_AW(OUT_AW), .CF_AW(CF_AW)) i_seq (
    .clk(clk), .rst(rst), .start(start), .sym_mode(sym_mode),
    .tap_count(tap_count), .fin(fin), .busy(busy), .sym(sym),
    .issue(issue), .issue_last(issue_last), .acc_clr(acc_clr),
    .fwd_addr(ring_raddr[0]), .mir_addr(ring_raddr[1]), .cf_addr(cf_addr),
    .out_we(out_we), .out_waddr(out_waddr)
  );

  // sample ring held twice so forward and mirrored reads share a cycle
  for (genvar g = 0; g < N_COPIES; g++) begin : g_ring
    fir_dp_ram #(.AW(IN_AW), .W(DW)) i_ring (
      .clk(clk), .we(smp_wr_en), .waddr(smp_wr_addr), .wdata(smp_wr_data),
      .raddr(ring_raddr[g]), .rdata(ring_rdata[g])
    );
  end

  fir_dp_ram #(.AW(CF_AW), .W(DW)) i_coef (
    .clk(clk), .we(cf_wr_en), .waddr(cf_wr_addr), .wdata(cf_wr_data),
    .raddr(cf_addr), .rdata(cf_rdata)
  );

  fir_mac i_mac (
    .clk(clk), .rst(rst), .acc_clr(acc_clr), .issue(issue),
    .issue_last(issue_last), .sym(sym),
    .smp_fwd(sample_t'(ring_rdata[0])), .smp_mir(sample_t'(ring_rdata[1])),
    .coef(sample_t'(cf_rdata)), .fin(fin), .result(result)
  );

  fir_dp_ram #(.AW(OUT_AW), .W(DW)) i_out (
    .clk(clk), .we(out_we), .waddr(out_waddr), .wdata(result),
    .raddr(res_rd_addr), .rdata(res_rd_data)
  );

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !out_we); // R7
endmodule

// File: tb/test_fir_sweep_engine.sv
module test_fir_sweep_engine;
  localparam int IN_AW  = 6;
  localparam int OUT_AW = 4;
  localparam int CF_AW  = 4;
  localparam int IN_D   = 1 << IN_AW;
  localparam int OUT_D  = 1 << OUT_AW;
  localparam int CF_D   = 1 << CF_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_wr_en = 1'b0, cf_wr_en = 1'b0, start = 1'b0, sym_mode = 1'b0;
  logic [IN_AW-1:0]  smp_wr_addr = '0;
  logic [15:0]       smp_wr_data = '0, cf_wr_data = '0;
  logic [CF_AW-1:0]  cf_wr_addr = '0;
  logic [OUT_AW-1:0] res_rd_addr = '0;
  logic [CF_AW:0]    tap_count = '0;
  logic [15:0]       res_rd_data;
  logic              busy;

  int mx [IN_D];
  int mc [CF_D];
  int base = 0, wp = 0, rem = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fir_sweep_engine #(.IN_AW(IN_AW), .OUT_AW(OUT_AW), .CF_AW(CF_AW)) i_fir_sweep_engine (
    .clk(clk), .rst(rst), .smp_wr_en(smp_wr_en), .smp_wr_addr(smp_wr_addr),
    .smp_wr_data(smp_wr_data), .cf_wr_en(cf_wr_en), .cf_wr_addr(cf_wr_addr),
    .cf_wr_data(cf_wr_data), .res_rd_addr(res_rd_addr), .res_rd_data(res_rd_data),
    .start(start), .sym_mode(sym_mode), .tap_count(tap_count), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: model follows the edge, busy compared at the falling edge
  task automatic tick();
    int eff;
    @(posedge clk);
    eff = sym_mode ? int'(tap_count) / 2 : int'(tap_count);
    if (smp_wr_en) mx[smp_wr_addr] = int'($signed(smp_wr_data));
    if (cf_wr_en)  mc[cf_wr_addr]  = int'($signed(cf_wr_data));
    if (rst) rem = 0;
    else if (rem > 0) begin
      rem--;
      if (rem == 0) begin
        base = (base + 1) % IN_D;
        wp   = (wp + 1) % OUT_D;
      end
    end else if (start && eff > 0 && int'(tap_count) <= CF_D)
      rem = eff + 3;
    @(negedge clk);
    chk(busy == (rem > 0), "R5 busy", int'(busy), int'(rem > 0));
  endtask

  function automatic int calc(input bit s, input int n, input int b);
    longint acc = 0, r;
    if (s)
      for (int i = 0; i < n / 2; i++)
        acc += longint'(mc[i]) * longint'(mx[(b + i) % IN_D] + mx[(b + n - 1 - i) % IN_D]);
    else
      for (int i = 0; i < n; i++)
        acc += longint'(mc[i]) * longint'(mx[(b + i) % IN_D]);
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic wr_smp(input int a, input int v);
    smp_wr_en = 1'b1; smp_wr_addr = IN_AW'(a % IN_D); smp_wr_data = 16'(v);
    tick();
    smp_wr_en = 1'b0;
  endtask

  task automatic wr_cf(input int a, input int v);
    cf_wr_en = 1'b1; cf_wr_addr = CF_AW'(a); cf_wr_data = 16'(v);
    tick();
    cf_wr_en = 1'b0;
  endtask

  task automatic do_sweep(input bit s, input int n, input bit poke, input bit wahead,
                          input string req);
    int e, slot, cyc, waddr, eff;
    eff   = s ? n / 2 : n;
    e     = calc(s, n, base);
    slot  = wp;
    waddr = (base + n) % IN_D;
    sym_mode = s; tap_count = (CF_AW+1)'(n); start = 1'b1;
    tick();
    start = 1'b0;
    cyc = 0;
    while (rem > 0 && cyc < 100) begin
      start = poke && (cyc < 3);        // R6: requests while busy
      if (wahead) begin                 // R9: writes during the sweep
        smp_wr_en = 1'b1; smp_wr_addr = IN_AW'(waddr); smp_wr_data = 16'(cyc * 311 - 700);
      end
      tick();
      cyc++;
    end
    start = 1'b0; smp_wr_en = 1'b0;
    chk(cyc == eff + 3, "R5 length", cyc, eff + 3);
    res_rd_addr = OUT_AW'(slot);        // R10 registered read
    tick();
    chk(int'($signed(res_rd_data)) == e, req, int'($signed(res_rd_data)), e);
  endtask

  task automatic try_null(input bit s, input int n);
    sym_mode = s; tap_count = (CF_AW+1)'(n); start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    chk(busy == 1'b0, "R7 ignored start", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
    rst = 1'b0;
    tick();
    chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);

    for (int i = 0; i < CF_D; i++) wr_cf(i, (i * 2731) % 8192 - 4096);
    for (int i = 0; i < IN_D; i++) wr_smp(i, (i * 1237) % 20000 - 10000);

    do_sweep(1'b0, 4,  1'b0, 1'b0, "R1 normal 4 taps, R8 first slot");
    do_sweep(1'b0, 16, 1'b0, 1'b0, "R1 normal full table, R3");
    do_sweep(1'b1, 8,  1'b0, 1'b0, "R2 symmetric 8 taps");
    do_sweep(1'b1, 16, 1'b0, 1'b0, "R2 symmetric full table");
    do_sweep(1'b0, 5,  1'b1, 1'b0, "R6 start while busy");
    do_sweep(1'b0, 6,  1'b0, 1'b0, "R6 next slot after ignored start");
    do_sweep(1'b0, 6,  1'b0, 1'b1, "R9 sweep with concurrent writes");
    do_sweep(1'b0, 6,  1'b0, 1'b0, "R9 uses sample written during sweep");

    try_null(1'b0, 0);
    try_null(1'b1, 1);
    try_null(1'b0, CF_D + 1);
    do_sweep(1'b1, 4, 1'b0, 1'b0, "R7 window did not move");

    wr_cf(0, 1);
    wr_smp(base, 16384);  do_sweep(1'b0, 1, 1'b0, 1'b0, "R4 round +half");
    wr_smp(base, -16384); do_sweep(1'b0, 1, 1'b0, 1'b0, "R4 round -half");
    wr_smp(base, 16383);  do_sweep(1'b0, 1, 1'b0, 1'b0, "R4 round below half");
    wr_smp(base, -16385); do_sweep(1'b0, 1, 1'b0, 1'b0, "R4 round below -half");

    for (int i = 0; i < CF_D; i++) wr_cf(i, 32767);
    for (int i = 0; i < CF_D; i++) wr_smp(base + i, 32767);
    do_sweep(1'b0, 16, 1'b0, 1'b0, "R4 positive saturation, R3");
    for (int i = 0; i < CF_D; i++) wr_smp(base + i, -32768);
    do_sweep(1'b0, 16, 1'b0, 1'b0, "R4 negative saturation, R3");

    wr_cf(0, 16384);
    wr_smp(base, 32767); wr_smp(base + 1, 32767);
    do_sweep(1'b1, 2, 1'b0, 1'b0, "R2 pre-add needs 17 bits");

    for (int i = 0; i < CF_D; i++) wr_cf(i, (i * 977) % 6000 - 3000);
    for (int k = 0; k < 70; k++)
      do_sweep(1'(k % 2), 4, 1'b0, 1'b0, "R8 ring wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule